// File: doc/BRIEF.md
# SAR Converter Host Sequencer (No-Busy Spanning Mode)

This block runs the host side of a serial successive-approximation converter in the mode where the configuration write and the result read share one transfer, and no busy indicator is used. A sample request raises the convert strobe. The strobe is held high long enough for the conversion to finish, and then lowered. The block then drives a mode-0 serial clock, which idles low. On each clock it shifts a 14-bit configuration word out on the data-in line and shifts the converted result in from the data-out line.

When readback is requested, the same transfer also collects the 14-bit configuration word that was in force for this conversion. In that case the frame is 30 falling edges long instead of 16. One clock after the last falling edge the strobe goes high again. The captured words are then shown for one cycle with a valid strobe. The strobe then stays high for a quiet period before it drops back to its idle low level.

The serial clock rate, the conversion hold time, the minimum strobe pulse width and the minimum spacing between conversion starts are all parameters. A request that arrives while a frame is running is kept and served once the spacing rule allows.

Top module: `adc_seq_host`

## Requirements
- R1: While reset is held, `cnv`, `sck`, `din` and `res_valid` are all low.
- R2: `sck` is low whenever `cnv` is high. Outside a transfer it is held low.
- R3: A conversion start raises `cnv`, and `cnv` stays high for exactly HOLD = max(CONV_CYC, CNVH_MIN) clock cycles before it falls.
- R4: Two successive conversion starts are at least CYC_MIN clock cycles apart.
- R5: During a transfer each `sck` half period lasts DIV clock cycles, and the first rising edge comes DIV cycles after `cnv` falls. A frame has exactly 16 falling edges when readback is off and 30 when it is on.
- R6: The `cfg_word` input is sampled at the conversion start, and its MSB is on `din` from that point. The next bit follows each `sck` falling edge. The converter therefore sees all 14 bits, MSB first, on the first 14 rising edges.
- R7: `sdo` is sampled at every `sck` falling edge, taking the value held just before that edge. The first 16 samples form `res_data`, MSB first.
- R8: `cnv` rises exactly one clock after the final falling edge, and `res_valid` is high for that one cycle only. When readback is on, `res_cfg` carries the next 14 samples. When it is off, `res_cfg` is zero. The `rdback_en` input is sampled at the conversion start.
- R9: After the frame-end rise, `cnv` stays high for exactly HOLD cycles, then returns low.
- R10: A request made while a frame is running is kept. It starts exactly one further conversion, so every request yields one valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_req | input | 1 | One-cycle request for a conversion |
| cfg_word | input | 14 | Configuration word sent in the next frame |
| rdback_en | input | 1 | Also collect the configuration readback in the next frame |
| cnv | output | 1 | Convert strobe to the converter |
| sck | output | 1 | Serial clock, mode 0 |
| din | output | 1 | Serial configuration data to the converter |
| sdo | input | 1 | Serial result data from the converter |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | 16 | Captured conversion result |
| res_cfg | output | 14 | Captured configuration readback, zero when readback is off |

## Verification
The embedded properties check the following on every cycle:
- the serial clock stays low while the strobe is high, and stops whenever no transfer is running;
- every high phase of the strobe lasts exactly HOLD cycles;
- conversion starts are never closer than CYC_MIN;
- the falling-edge count never goes past the frame length;
- the valid strobe is a single cycle that lines up with the strobe's rise.

Some behaviour can only be shown by the bench's converter model across a sweep of frames. That model checks that the configuration bits arrive intact and in order. It checks that result and readback words come back bit-exact, including the all-ones and all-zeros patterns. It counts 16 or 30 edges depending on the mode. It also checks that a request made in the middle of a frame produces exactly one extra conversion.

// File: rtl/adc_seq_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes a converter with a 16-bit result and a 14-bit configuration word.
package adc_seq_pkg;
    localparam int RES_BITS = 16;
    localparam int CFG_BITS = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_XFER,
        ST_DONE,
        ST_QUIET
    } seq_state_t;
endpackage

// File: rtl/adc_seq_sckgen.sv
// Module: serial clock generator.
// While run is high, sck toggles every DIV clock cycles, starting from low.
// fall_tick marks the clock edge at which sck goes from high to low.
// Assumes DIV >= 1. When run is low, sck and the divider are held at zero.
module adc_seq_sckgen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic fall_tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;
    logic          wrap;

    assign wrap      = (div_q == DW'(DIV - 1));
    assign fall_tick = run && wrap && sck;

    // Count the half period and toggle sck when the count wraps.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            sck   <= 1'b0;
        end else if (wrap) begin
            div_q <= '0;
            sck   <= ~sck;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_SCK_STOPS: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !sck); // R2
endmodule

// File: rtl/adc_seq_shifter.sv
// Module: full-duplex shift engine.
// load captures the configuration word and clears the receive word.
// Each fall_tick shifts the next configuration bit onto din and samples sdo into the receive word.
// Assumes the controller stops issuing fall_tick at the end of the frame.
module adc_seq_shifter #(
    parameter int CFG_W = 14,
    parameter int RX_W  = 30,
    localparam int CW   = $clog2(RX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             fall_tick,
    input  logic             sdo,
    output logic             din,
    output logic [RX_W-1:0]  rx_word,
    output logic [CW-1:0]    nfall
);
    logic [CFG_W-1:0] tx_q;

    assign din = tx_q[CFG_W-1];

    // Load at the conversion start, then shift both directions on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q    <= '0;
            rx_word <= '0;
            nfall   <= '0;
        end else if (load) begin
            tx_q    <= cfg_in;
            rx_word <= '0;
            nfall   <= '0;
        end else if (fall_tick) begin
            tx_q    <= {tx_q[CFG_W-2:0], 1'b0};
            rx_word <= {rx_word[RX_W-2:0], sdo};
            nfall   <= nfall + 1'b1;
        end
    end

    AST_FALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) nfall <= CW'(RX_W)); // R5
endmodule

// File: rtl/adc_seq_host.sv
// Module: host sequencer for a serial converter that reads and writes in the same frame, without a busy indicator.
// Frame order:
//   1. A request raises cnv and holds it high for HOLD cycles.
//   2. cnv is lowered and the transfer runs for 16 or 30 falling edges of sck.
//   3. One clock later cnv rises again and the result is posted with res_valid.
//   4. cnv stays high for HOLD cycles, then returns low.
// Assumes CONV_CYC covers the converter's maximum conversion time, and that CYC_MIN >= 1.
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int DIV      = 2,
    parameter int CONV_CYC = 6,
    parameter int CNVH_MIN = 3,
    parameter int CYC_MIN  = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_req,
    input  logic [CFG_BITS-1:0] cfg_word,
    input  logic                rdback_en,
    output logic                cnv,
    output logic                sck,
    output logic                din,
    input  logic                sdo,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic [CFG_BITS-1:0] res_cfg
);
    localparam int HOLD = (CONV_CYC > CNVH_MIN) ? CONV_CYC : CNVH_MIN;
    localparam int HW   = $clog2(HOLD + 1);
    localparam int GW   = $clog2(CYC_MIN + 1);
    localparam int RX_W = RES_BITS + CFG_BITS;
    localparam int NF_W = $clog2(RX_W + 1);

    seq_state_t        state_q;
    logic [HW-1:0]     hold_q;
    logic [GW-1:0]     gap_q;
    logic              pend_q;
    logic              rb_q;
    logic              start;
    logic              run;
    logic              fall_tick;
    logic              last_fall;
    logic [RX_W-1:0]   rx_word;
    logic [NF_W-1:0]   nfall;

    assign run       = (state_q == ST_XFER);
    assign start     = (state_q == ST_IDLE) && (pend_q || sample_req) && (gap_q == GW'(CYC_MIN - 1));
    assign last_fall = fall_tick && (nfall == (rb_q ? NF_W'(RX_W - 1) : NF_W'(RES_BITS - 1)));

    adc_seq_sckgen #(.DIV(DIV)) i_sckgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sck       (sck),
        .fall_tick (fall_tick)
    );

    adc_seq_shifter #(.CFG_W(CFG_BITS), .RX_W(RX_W)) i_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .cfg_in    (cfg_word),
        .fall_tick (fall_tick),
        .sdo       (sdo),
        .din       (din),
        .rx_word   (rx_word),
        .nfall     (nfall)
    );

    // Keep a request that cannot start yet.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (start)      pend_q <= 1'b0;
        else if (sample_req) pend_q <= 1'b1;
    end

    // Count cycles since the last start, saturating at the minimum cycle time.
    always_ff @(posedge clk) begin
        if (!rst_n)                          gap_q <= GW'(CYC_MIN - 1);
        else if (start)                      gap_q <= '0;
        else if (gap_q != GW'(CYC_MIN - 1))  gap_q <= gap_q + 1'b1;
    end

    // Frame sequencer: hold, transfer, post the result, quiet period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hold_q    <= '0;
            rb_q      <= 1'b0;
            cnv       <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_cfg   <= '0;
        end else begin
            res_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    cnv     <= 1'b1;
                    hold_q  <= '0;
                    rb_q    <= rdback_en;
                    state_q <= ST_CONV;
                end
                ST_CONV: if (hold_q == HW'(HOLD - 1)) begin
                    cnv     <= 1'b0;
                    state_q <= ST_XFER;
                end else begin
                    hold_q <= hold_q + 1'b1;
                end
                ST_XFER: if (last_fall) state_q <= ST_DONE;
                ST_DONE: begin
                    cnv       <= 1'b1;
                    hold_q    <= '0;
                    res_valid <= 1'b1;
                    res_data  <= rb_q ? rx_word[RX_W-1:CFG_BITS] : rx_word[RES_BITS-1:0];
                    res_cfg   <= rb_q ? rx_word[CFG_BITS-1:0] : '0;
                    state_q   <= ST_QUIET;
                end
                ST_QUIET: if (hold_q == HW'(HOLD - 1)) begin
                    cnv     <= 1'b0;
                    state_q <= ST_IDLE;
                end else begin
                    hold_q <= hold_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Checker state: length of the current cnv high phase and cycles since the last start.
    logic [HW-1:0] chk_hi;
    logic [GW-1:0] chk_gap;
    logic          cnv_d;
    logic          start_seen;

    assign start_seen = cnv && !cnv_d && !res_valid;

    // Track the cnv high width and the start spacing, independent of the sequencer counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_hi  <= '0;
            chk_gap <= GW'(CYC_MIN);
            cnv_d   <= 1'b0;
        end else begin
            cnv_d   <= cnv;
            chk_hi  <= !cnv ? '0 : ((chk_hi == HW'(HOLD)) ? chk_hi : chk_hi + 1'b1);
            chk_gap <= start_seen ? GW'(1) : ((chk_gap == GW'(CYC_MIN)) ? chk_gap : chk_gap + 1'b1);
        end
    end

    AST_SCK_LOW_CNV:  assert property (@(posedge clk) disable iff (!rst_n) cnv |-> !sck); // R2
    AST_CNV_WIDTH:    assert property (@(posedge clk) disable iff (!rst_n) $fell(cnv) |-> $past(chk_hi) == HW'(HOLD - 1)); // R3
    AST_CYC_MIN:      assert property (@(posedge clk) disable iff (!rst_n) start_seen |-> chk_gap >= GW'(CYC_MIN)); // R4
    AST_VALID_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R8
    AST_VALID_ON_CNV: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $rose(cnv)); // R8
endmodule

// File: tb/test_adc_seq_host.sv
// Bench: a behavioural converter model plus a sweep of frames, with and without readback.
// Every expected value is computed from the frame index.
module test_adc_seq_host;
    localparam int DIV      = 2;
    localparam int CONV_CYC = 6;
    localparam int CNVH_MIN = 3;
    localparam int CYC_MIN  = 80;
    localparam int HOLD     = (CONV_CYC > CNVH_MIN) ? CONV_CYC : CNVH_MIN;
    localparam int NFRAMES  = 24;
    localparam logic [13:0] CFG_INIT = 14'h2A5C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_req = 1'b0;
    logic [13:0] cfg_word;
    logic        rdback_en;
    logic        cnv, sck, din, sdo;
    logic        res_valid;
    logic [15:0] res_data;
    logic [13:0] res_cfg;

    int n_checks = 0;
    int n_errs   = 0;
    int cyc      = 0;
    int n_start  = 0;
    int nv       = 0;

    always #2 clk = ~clk;

    // Advance the cycle count away from the active edge.
    always @(negedge clk) cyc = cyc + 1;

    function automatic logic [15:0] res_of(input int f);
        if (f == 2) return 16'hFFFF;
        if (f == 3) return 16'h0000;
        return 16'((f * 16'h1F3D) + 16'h0F0F);
    endfunction

    function automatic logic [13:0] cfg_of(input int f);
        if (f == 2) return 14'h3FFF;
        if (f == 3) return 14'h0000;
        return 14'((f * 14'h0A53) ^ 14'h1234);
    endfunction

    function automatic logic rb_of(input int f);
        return (f % 3) != 0;
    endfunction

    assign cfg_word  = cfg_of(n_start);
    assign rdback_en = rb_of(n_start);

    adc_seq_host #(.DIV(DIV), .CONV_CYC(CONV_CYC), .CNVH_MIN(CNVH_MIN), .CYC_MIN(CYC_MIN)) i_adc_seq_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_req (sample_req),
        .cfg_word   (cfg_word),
        .rdback_en  (rdback_en),
        .cnv        (cnv),
        .sck        (sck),
        .din        (din),
        .sdo        (sdo),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_cfg    (res_cfg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    endtask

    // Converter model state.
    bit          phase = 1'b0;
    bit          xfer  = 1'b0;
    int          t_start = 0, t_prev = 0, t_end = 0, t_cfall = 0, t_lfall = 0;
    int          falls = 0, nrise = 0;
    logic [13:0] rcv = '0;
    logic [13:0] cur_cfg = CFG_INIT;
    logic [29:0] shreg = '0;

    assign sdo = shreg[29];

    // Rising cnv: a conversion start, or the end of a frame.
    always @(posedge cnv) begin
        if (!phase) begin
            if (n_start > 0) chk((cyc - t_prev) >= CYC_MIN, "R4 start spacing", cyc - t_prev, CYC_MIN);
            t_prev  = cyc;
            t_start = cyc;
            phase   = 1'b1;
            n_start = n_start + 1;
        end else begin
            chk(falls == (rb_of(n_start - 1) ? 30 : 16), "R5 falling edge count", falls, rb_of(n_start - 1) ? 30 : 16);
            chk(nrise >= 14 && rcv == cfg_of(n_start - 1), "R6 configuration received", int'(rcv), int'(cfg_of(n_start - 1)));
            chk((cyc - t_lfall) == 1, "R8 cnv rise after last fall", cyc - t_lfall, 1);
            if (nrise >= 14) cur_cfg = rcv;
            t_end = cyc;
            xfer  = 1'b0;
            phase = 1'b0;
        end
    end

    // Falling cnv: start of the transfer, or the end of the quiet period.
    always @(negedge cnv) begin
        if (phase) begin
            chk((cyc - t_start) == HOLD, "R3 cnv high width", cyc - t_start, HOLD);
            shreg   = {res_of(n_start - 1), cur_cfg};
            falls   = 0;
            nrise   = 0;
            rcv     = '0;
            t_cfall = cyc;
            xfer    = 1'b1;
        end else if (rst_n) begin
            chk((cyc - t_end) == HOLD, "R9 quiet width", cyc - t_end, HOLD);
        end
    end

    // Rising sck: the model samples din.
    always @(posedge sck) begin
        chk(!cnv, "R2 sck while cnv high", 1, 0);
        if (xfer) begin
            if (nrise == 0) chk((cyc - t_cfall) == DIV, "R5 first rise delay", cyc - t_cfall, DIV);
            if (nrise < 14) rcv = {rcv[12:0], din};
            nrise = nrise + 1;
        end
    end

    // Falling sck: the model shifts out its next bit.
    always @(negedge sck) begin
        if (xfer) begin
            falls   = falls + 1;
            t_lfall = cyc;
            shreg   = shreg << 1;
        end
    end

    // Compare each posted result with the value computed from its frame index.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            logic [13:0] erb;
            erb = rb_of(nv) ? ((nv == 0) ? CFG_INIT : cfg_of(nv - 1)) : 14'h0;
            chk(res_data == res_of(nv), "R7 result word", int'(res_data), int'(res_of(nv)));
            chk(res_cfg == erb, "R8 readback word", int'(res_cfg), int'(erb));
            nv = nv + 1;
        end
    end

    task automatic pulse_req();
        @(negedge clk);
        sample_req = 1'b1;
        @(negedge clk);
        sample_req = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(cnv == 1'b0 && sck == 1'b0 && din == 1'b0 && res_valid == 1'b0, "R1 reset outputs",
            int'({cnv, sck, din, res_valid}), 0);
        rst_n = 1'b1;
        // Scenario A: one request at a time, with varying idle gaps.
        for (int f = 0; f < 12; f++) begin
            pulse_req();
            wait (nv == f + 1);
            repeat (f % 4) @(negedge clk);
        end
        // Scenario B: a second request made while the first frame is running.
        for (int p = 0; p < 6; p++) begin
            int base;
            base = 12 + 2 * p;
            pulse_req();
            wait (n_start == base + 1);
            repeat (10) @(negedge clk);
            pulse_req();
            wait (nv == base + 2);
        end
        repeat (300) @(negedge clk);
        chk(nv == NFRAMES && n_start == NFRAMES, "R10 one result per request", nv, NFRAMES);
        chk(cnv == 1'b0 && sck == 1'b0, "R2 idle levels", int'({cnv, sck}), 0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        finish_run();
    end
endmodule